// File: doc/BRIEF.md
# Unipolar Sine-Triangle Full-Bridge Modulator

This block turns a stream of signed modulating samples into gate commands for the four switches of a single-phase full bridge. An internal up/down counter sweeps a symmetric triangular carrier between a negative and a positive peak set by the `peak_i` input. Leg A compares the held modulating sample against this carrier. Leg B compares the negated sample against the same carrier. Because the two legs use opposite references on one shared carrier, the voltage across the load takes three levels (positive, zero, negative). The load pulses repeat at twice the carrier rate, so the ripple is easier to filter than with two-level switching of diagonal pairs.

Samples arrive on a valid/ready interface. The block takes a new sample only in a carrier turning cycle, at the peak or the valley, so the reference never changes inside a half-period. `ref_ready_o` does not depend on `ref_valid_i`. An upstream source may hold its data valid indefinitely. The block takes at most one sample per half-period, and data offered while ready is low stays with the source. If no sample is offered at a turning point, the previous one stays in force. Samples beyond the carrier peak are clamped and mark over-modulation on a sticky flag. Sine generation and dead-time insertion belong to neighbouring blocks.

Top module: `uni_hbridge_pwm`

## Requirements
- R1: Let P be `peak_i`, with a value of zero treated as one. While enabled, the carrier moves one step per clock between -P and +P and reverses at each end, so a full carrier period lasts 4P clocks and turning cycles occur every 2P clocks. While disabled or in reset, the carrier is parked at the valley.
- R2: The gate outputs are registered. Leg A upper (`gate_o[0]`) turns on when the held sample m exceeds the carrier, or equals it while the carrier is rising. Otherwise leg A lower (`gate_o[1]`) is on. Over one carrier period, leg A upper is therefore on for exactly 2(m+P) clocks.
- R3: Leg B uses -m against the same carrier. Leg B upper (`gate_o[2]`) is on for 2(P-m) clocks per period, and leg B lower (`gate_o[3]`) is on for the rest.
- R4: With m = 0, each leg's upper switch is on for exactly half of every carrier period (2P of 4P clocks).
- R5: `load_o` is 2'b01 (+1) when leg A upper and leg B lower are on. It is 2'b11 (-1) when leg B upper and leg A lower are on. It is 2'b00 (zero) otherwise. The code 2'b10 never appears.
- R6: For 0 < |m| < P, the load code leaves zero twice per carrier period, always toward the sign of m, while each leg's upper switch turns on only once per period.
- R7: `ref_ready_o` is high only while `en_i` is high and the carrier is in a turning cycle. A sample is taken on a clock edge where valid and ready are both high. Data offered while ready is low has no effect on the duty cycle.
- R8: An accepted sample above +P or below -P is clamped to that limit, which gives 100 % or 0 % leg A upper duty. It also sets `ovm_o`, which stays set until reset. A sample of exactly ±P does not set the flag.
- R9: On the first clock edge after `en_i` falls, all four gates go low and `load_o` becomes 2'b00. `ref_ready_o` drops together with `en_i`.
- R10: Reset (synchronous, `rst_ni` low) clears the gates, `load_o`, `ovm_o` and the held sample to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| en_i | input | 1 | Run enable; low parks the carrier and turns all gates off |
| peak_i | input | CW-1 | Carrier peak P (unsigned, 0 treated as 1) |
| ref_data_i | input | CW | Signed modulating sample |
| ref_valid_i | input | 1 | Sample valid |
| ref_ready_o | output | 1 | Sample accepted this cycle if valid |
| gate_o | output | 4 | {B lower, B upper, A lower, A upper} |
| load_o | output | 2 | Load state: 01 = +1, 11 = -1, 00 = zero |
| ovm_o | output | 1 | Sticky over-modulation flag |

## Verification
A carrier that has slipped by one step, turned late or run past the peak shows up within one carrier period. It appears either as a wrong count of on-clocks for a leg's upper switch or as a ready pulse at the wrong spacing. A held sample that changed mid-period, or a leg B that was not negated, breaks the 2(m+P) and 2(P-m) duty counts within a single period. It also breaks the per-clock comparison against the reference model on the next clock edge. A wrong load decode or a non-sticky flag appears on the same cycle as the gate pattern that exposes it.

// File: rtl/upwm_pkg.sv
package upwm_pkg;
  typedef enum logic [1:0] {
    LD_ZERO = 2'b00,
    LD_POS  = 2'b01,
    LD_NEG  = 2'b11
  } load_e;

  typedef struct packed {
    logic b_lo;
    logic b_hi;
    logic a_lo;
    logic a_hi;
  } gates_t;
endpackage

// File: rtl/tri_carrier.sv
module tri_carrier #(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [CW-2:0]        peak_i,
  output logic signed [CW-1:0] cnt_o,
  output logic signed [CW-1:0] pk_o,
  output logic                 rising_o,
  output logic                 turn_o
);
  logic signed [CW-1:0] pk_s, cnt_q;
  logic up_q, turn;

  assign pk_s = (peak_i == '0) ? CW'(1) : CW'({1'b0, peak_i});
  assign turn = up_q ? (cnt_q >= pk_s) : (cnt_q <= -pk_s);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      cnt_q <= -pk_s;
      up_q  <= 1'b0;
    end else if (turn) begin
      up_q  <= ~up_q;
      cnt_q <= up_q ? cnt_q - 1'b1 : cnt_q + 1'b1;
    end else begin
      cnt_q <= up_q ? cnt_q + 1'b1 : cnt_q - 1'b1;
    end
  end

  assign cnt_o    = cnt_q;
  assign pk_o     = pk_s;
  assign rising_o = up_q;
  assign turn_o   = turn;
endmodule

// File: rtl/ref_latch.sv
module ref_latch #(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic                 turn_i,
  input  logic signed [CW-1:0] pk_i,
  input  logic signed [CW-1:0] data_i,
  input  logic                 valid_i,
  output logic                 ready_o,
  output logic signed [CW-1:0] m_o,
  output logic                 ovm_o
);
  logic signed [CW-1:0] m_q;
  logic ovm_q, take, above, below;

  assign ready_o = en_i & turn_i;
  assign take    = ready_o & valid_i;
  assign above   = data_i > pk_i;
  assign below   = data_i < -pk_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      m_q   <= '0;
      ovm_q <= 1'b0;
    end else if (take) begin
      m_q   <= above ? pk_i : (below ? -pk_i : data_i);
      ovm_q <= ovm_q | above | below;
    end
  end

  assign m_o   = m_q;
  assign ovm_o = ovm_q;
endmodule

// File: rtl/leg_cmp.sv
module leg_cmp #(
  parameter int CW     = 12,
  parameter int INVERT = 0
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [CW-1:0] cnt_i,
  input  logic                 rising_i,
  input  logic signed [CW-1:0] m_i,
  output logic                 hi_o,
  output logic                 lo_o
);
  logic signed [CW-1:0] ref_v;
  logic on, hi_q, lo_q;

  assign ref_v = (INVERT != 0) ? -m_i : m_i;
  assign on    = (ref_v > cnt_i) || ((ref_v == cnt_i) && rising_i);

  always_ff @(posedge clk_i) begin
    if (!rst_ni || !en_i) begin
      hi_q <= 1'b0;
      lo_q <= 1'b0;
    end else begin
      hi_q <= on;
      lo_q <= ~on;
    end
  end

  assign hi_o = hi_q;
  assign lo_o = lo_q;
endmodule

// File: rtl/uni_hbridge_pwm.sv
module uni_hbridge_pwm
  import upwm_pkg::*;
#(
  parameter int CW = 12
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic [CW-2:0]        peak_i,
  input  logic signed [CW-1:0] ref_data_i,
  input  logic                 ref_valid_i,
  output logic                 ref_ready_o,
  output logic [3:0]           gate_o,
  output logic [1:0]           load_o,
  output logic                 ovm_o
);
  localparam int NLEG = 2;

  logic signed [CW-1:0] cnt_w, pk_w, m_w;
  logic rising_w, turn_w;
  logic [NLEG-1:0] hi_w, lo_w;
  gates_t g;
  load_e  ld;

  tri_carrier #(.CW(CW)) u_car (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .peak_i(peak_i),
    .cnt_o(cnt_w), .pk_o(pk_w), .rising_o(rising_w), .turn_o(turn_w)
  );

  ref_latch #(.CW(CW)) u_ref (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .turn_i(turn_w),
    .pk_i(pk_w), .data_i(ref_data_i), .valid_i(ref_valid_i),
    .ready_o(ref_ready_o), .m_o(m_w), .ovm_o(ovm_o)
  );

  for (genvar k = 0; k < NLEG; k++) begin : g_leg
    leg_cmp #(.CW(CW), .INVERT(k)) u_leg (
      .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .cnt_i(cnt_w),
      .rising_i(rising_w), .m_i(m_w), .hi_o(hi_w[k]), .lo_o(lo_w[k])
    );
  end

  assign g = {lo_w[1], hi_w[1], lo_w[0], hi_w[0]};

  always_comb begin
    if (g.a_hi && g.b_lo)      ld = LD_POS;
    else if (g.b_hi && g.a_lo) ld = LD_NEG;
    else                       ld = LD_ZERO;
  end

  assign gate_o = g;
  assign load_o = ld;
endmodule

// File: rtl/upwm_chk.sv
module upwm_chk #(
  parameter int CW = 12
) (
  input logic                 clk_i,
  input logic                 rst_ni,
  input logic                 en_i,
  input logic                 ref_valid_i,
  input logic                 ref_ready_o,
  input logic [3:0]           gate_o,
  input logic [1:0]           load_o,
  input logic                 ovm_o,
  input logic signed [CW-1:0] cnt,
  input logic signed [CW-1:0] m
);
  assert_carrier_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> (cnt == $past(cnt) + 1 || cnt == $past(cnt) - 1));

  assert_leg_complement_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    en_i |=> ((gate_o[0] ^ gate_o[1]) && (gate_o[2] ^ gate_o[3])));

  assert_load_pos_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o == 2'b01) |-> (gate_o[0] && gate_o[3]));

  assert_load_neg_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_o == 2'b11) |-> (gate_o[2] && gate_o[1]));

  assert_no_code_two_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_o != 2'b10);

  assert_ready_gated_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ref_ready_o |-> en_i);

  assert_hold_sample_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ref_valid_i && ref_ready_o) |=> $stable(m));

  assert_ovm_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovm_o |=> ovm_o);

  assert_off_when_idle_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> (gate_o == 4'b0000 && load_o == 2'b00));
endmodule

bind uni_hbridge_pwm upwm_chk #(.CW(CW)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .ref_valid_i(ref_valid_i),
  .ref_ready_o(ref_ready_o), .gate_o(gate_o), .load_o(load_o), .ovm_o(ovm_o),
  .cnt(cnt_w), .m(m_w)
);

// File: tb/uni_hbridge_pwm_test.sv
module uni_hbridge_pwm_test;
  localparam int CW = 12;

  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0, valid = 1'b0;
  logic [CW-2:0] peak = 11'd8;
  logic signed [CW-1:0] data = '0;
  logic ready, ovm;
  logic [3:0] gate;
  logic [1:0] load;
  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  uni_hbridge_pwm #(.CW(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .peak_i(peak),
    .ref_data_i(data), .ref_valid_i(valid), .ref_ready_o(ready),
    .gate_o(gate), .load_o(load), .ovm_o(ovm)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // reference model: pushes the expected outputs after every edge
  typedef struct {
    logic [3:0] g;
    logic [1:0] ld;
    logic       ov;
    logic       turn;
  } exp_t;
  exp_t sb_q[$];
  int mc = 0, mm = 0, mpk = 1;
  bit mup = 0, mov = 0;

  always @(posedge clk) begin : model
    exp_t e;
    bit ahi, bhi, trn;
    int d;
    mpk = (peak == 0) ? 1 : int'(peak);
    d = int'(data);
    if (!rst_n) begin
      mc = -mpk; mup = 0; mm = 0; mov = 0; e.g = 4'b0;
    end else if (!en) begin
      mc = -mpk; mup = 0; e.g = 4'b0;
    end else begin
      ahi = (mm > mc) || (mm == mc && mup);
      bhi = (-mm > mc) || (-mm == mc && mup);
      e.g = {~bhi, bhi, ~ahi, ahi};
      trn = mup ? (mc >= mpk) : (mc <= -mpk);
      if (trn && valid) begin
        if (d > mpk) begin mm = mpk; mov = 1; end
        else if (d < -mpk) begin mm = -mpk; mov = 1; end
        else mm = d;
      end
      if (trn) mup = ~mup;
      mc = mup ? mc + 1 : mc - 1;
    end
    e.ld   = (e.g[0] && e.g[3]) ? 2'b01 : ((e.g[2] && e.g[1]) ? 2'b11 : 2'b00);
    e.ov   = mov;
    e.turn = mup ? (mc >= mpk) : (mc <= -mpk);
    sb_q.push_back(e);
  end

  initial begin : monitor
    forever begin
      exp_t e;
      @(posedge clk); #5;
      if (sb_q.size() != 0) begin
        e = sb_q.pop_front();
        chk(gate[1:0] == e.g[1:0], "R2 leg A gates", int'(gate[1:0]), int'(e.g[1:0]));
        chk(gate[3:2] == e.g[3:2], "R3 leg B gates", int'(gate[3:2]), int'(e.g[3:2]));
        chk(load == e.ld, "R5 load code", int'(load), int'(e.ld));
        chk(ovm == e.ov, "R8 flag", int'(ovm), int'(e.ov));
        chk(ready == (e.turn && en), "R7 ready", int'(ready), int'(e.turn && en));
      end
    end
  end

  // counts over n samples, transitions counted cyclically over the window
  task automatic count_win(input int n, output int a_on, output int b_on,
                           output int pos_p, output int neg_p, output int a_rise);
    logic [3:0] g0, gp;
    logic [1:0] l0, lp;
    a_on = 0; b_on = 0; pos_p = 0; neg_p = 0; a_rise = 0;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #5;
      if (i == 0) begin g0 = gate; l0 = load; end
      else begin
        if (lp == 2'b00 && load == 2'b01) pos_p++;
        if (lp == 2'b00 && load == 2'b11) neg_p++;
        if (!gp[0] && gate[0]) a_rise++;
      end
      a_on += int'(gate[0]);
      b_on += int'(gate[2]);
      gp = gate; lp = load;
    end
    if (lp == 2'b00 && l0 == 2'b01) pos_p++;
    if (lp == 2'b00 && l0 == 2'b11) neg_p++;
    if (!gp[0] && g0[0]) a_rise++;
  endtask

  task automatic wait_ready();
    do begin @(posedge clk); #5; end while (!ready);
  endtask

  task automatic ready_gap(output int gap);
    wait_ready();
    gap = 0;
    do begin @(posedge clk); #5; gap++; end while (!ready);
  endtask

  task automatic settle(input int p);
    repeat (8 * p + 4) @(negedge clk);
  endtask

  task automatic duty(input int p, input int m, input string tag);
    int a, b, pp, np, ar;
    count_win(4 * p, a, b, pp, np, ar);
    chk(a == 2 * (m + p), {tag, " leg A on-clocks"}, a, 2 * (m + p));
    chk(b == 2 * (p - m), {tag, " leg B on-clocks"}, b, 2 * (p - m));
  endtask

  task automatic run_all();
    int a, b, pp, np, ar, gap;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(gate == 4'b0, "R10 gates in reset", int'(gate), 0);
    chk(load == 2'b00, "R10 load in reset", int'(load), 0);
    chk(ovm == 1'b0, "R10 flag in reset", int'(ovm), 0);
    chk(ready == 1'b0, "R10 ready in reset", int'(ready), 0);
    @(negedge clk); rst_n = 1'b1; en = 1'b1; valid = 1'b0;
    settle(8);
    duty(8, 0, "R4 R10 zero sample");
    // R1 turning spacing
    ready_gap(gap);
    chk(gap == 16, "R1 turn spacing P=8", gap, 16);
    // R8 exact peak: full duty, no flag
    @(negedge clk); valid = 1'b1; data = 12'sd8;
    settle(8);
    duty(8, 8, "R8 exact peak");
    chk(ovm == 1'b0, "R8 no flag at exact peak", int'(ovm), 0);
    // R2 R3 R6 positive sample
    @(negedge clk); data = 12'sd3;
    settle(8);
    count_win(32, a, b, pp, np, ar);
    chk(a == 22, "R2 leg A on-clocks m=3", a, 22);
    chk(b == 10, "R3 leg B on-clocks m=3", b, 10);
    chk(pp == 2, "R6 positive pulses per period", pp, 2);
    chk(np == 0, "R6 no negative pulses", np, 0);
    chk(ar == 1, "R6 leg A turn-ons per period", ar, 1);
    // negative sample
    @(negedge clk); data = -12'sd5;
    settle(8);
    count_win(32, a, b, pp, np, ar);
    chk(a == 6, "R2 leg A on-clocks m=-5", a, 6);
    chk(b == 26, "R3 leg B on-clocks m=-5", b, 26);
    chk(np == 2, "R6 negative pulses per period", np, 2);
    // R8 saturation high, then low, then sticky
    @(negedge clk); data = 12'sd100;
    settle(8);
    duty(8, 8, "R8 clamp high");
    chk(ovm == 1'b1, "R8 flag after clamp", int'(ovm), 1);
    @(negedge clk); data = -12'sd2048;
    settle(8);
    duty(8, -8, "R8 clamp low");
    @(negedge clk); data = 12'sd2;
    settle(8);
    chk(ovm == 1'b1, "R8 flag sticky", int'(ovm), 1);
    // R7 data offered while not ready is ignored
    @(negedge clk); data = 12'sd4;
    settle(8);
    @(negedge clk); valid = 1'b0;
    wait_ready();
    repeat (3) @(negedge clk);
    chk(ready == 1'b0, "R7 ready low mid-period", int'(ready), 0);
    valid = 1'b1; data = -12'sd7;
    @(negedge clk); valid = 1'b0;
    wait_ready();
    duty(8, 4, "R7 mid-period offer ignored");
    // R9 disable
    @(negedge clk); en = 1'b0; #1;
    chk(ready == 1'b0, "R9 ready drops with enable", int'(ready), 0);
    @(posedge clk); #5;
    chk(gate == 4'b0, "R9 gates off", int'(gate), 0);
    chk(load == 2'b00, "R9 load zero", int'(load), 0);
    // R1 zero peak treated as one
    @(negedge clk); peak = '0; valid = 1'b1; data = 12'sd0;
    @(negedge clk); en = 1'b1;
    settle(1);
    duty(1, 0, "R1 zero peak");
    ready_gap(gap);
    chk(gap == 2, "R1 turn spacing P=0", gap, 2);
    // R1 R2 R3 full-range carrier
    @(negedge clk); en = 1'b0;
    @(negedge clk); peak = 11'd2047; data = 12'sd1000;
    @(negedge clk); en = 1'b1;
    settle(2047);
    duty(2047, 1000, "R2 R3 large peak");
    ready_gap(gap);
    chk(gap == 4094, "R1 turn spacing P=2047", gap, 4094);
  endtask

  initial begin : main
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        chk(1'b0, "watchdog expired", 0, 1);
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule